// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers interrupt requests that arrive as (level, source) pairs. Each numbered level keeps one pending bit per source. A level counts as active while any of its source bits is set. Separate strobes post one source, clear one source, or wipe every level at once.

The active levels in the external band are merged with a software request vector. Software request bits are remapped into a low priority band. The highest resulting priority is compared with the processor's current threshold. When that priority is strictly higher and the instruction address is word aligned, the block raises a take request. On every cycle with the take request high, the priority and a summary bit vector are captured into holding registers. A later commit strobe moves them into the architectural summary and identifier registers.

Top module: `intc_leveled`

## Requirements
- R1: A valid post with level L and source k, both in range, sets that source's pending bit, so level L is active from the next cycle.
- R2: A valid clear of level L, source k drops that bit. Level L stays active while any other source bit of L is still set, and it goes inactive once all of its source bits are zero.
- R3: `clr_all` empties every level in a single cycle. It overrides a post or clear issued in the same cycle.
- R4: `int_avail` is 1 exactly when at least one level (any level from 0 to LEVELS-1) is active and `pc_low` equals 2'b00. Software requests alone do not raise it.
- R5: Each set `sw_req` bit i with SW_MIN <= i < SW_MAX (defaults 4 and 16) yields the candidate priority i-SW_MIN+1 and sets bit i of the summary. Bits of `sw_req` outside that band have no effect.
- R6: Each active level i with EXT_MIN <= i < EXT_MAX (defaults 16 and 32) yields the candidate priority i and sets summary bit i. The chosen priority is the largest candidate, with external levels ranked above software ones, and the summary is the OR of all candidate bits.
- R7: `take_req` is 1 exactly when `pc_low` equals 2'b00 and the chosen priority is strictly greater than `threshold`. In any cycle where it is 1, the priority and summary are captured into holding registers, and `info_pending` is 1 from the next cycle.
- R8: A `commit` while `info_pending` is 1 copies the held priority to `intid_q` and the held summary to `summary_q`. It clears `info_pending` unless a new capture happens in the same cycle.
- R9: A post or clear whose level is at least LEVELS or whose source is at least SRCS changes no pending state. It sets the sticky `err` flag, which only reset clears.
- R10: A `commit` while `info_pending` is 0 leaves `intid_q` and `summary_q` unchanged and sets `err`.
- R11: Reset (active-low `rst_n`) clears all pending bits, the holding registers, `summary_q`, `intid_q`, `info_pending` and `err`.
- R12: When a post and a clear name the same level and source in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_v | input | 1 | Post strobe |
| post_lvl | input | LVL_W (6) | Level to post |
| post_src | input | SRC_W (4) | Source index to post |
| clr_v | input | 1 | Clear strobe |
| clr_lvl | input | LVL_W (6) | Level to clear |
| clr_src | input | SRC_W (4) | Source index to clear |
| clr_all | input | 1 | Empty every level |
| sw_req | input | LEVELS (32) | Software request vector |
| threshold | input | PRIO_W (5) | Current processor priority threshold |
| pc_low | input | 2 | Two low bits of the program counter |
| commit | input | 1 | Moves the held info into the output registers |
| int_avail | output | 1 | Some level active and address aligned |
| take_req | output | 1 | Interrupt should be taken |
| summary_q | output | LEVELS (32) | Committed summary vector |
| intid_q | output | PRIO_W (5) | Committed priority identifier |
| info_pending | output | 1 | Held info awaits commit |
| err | output | 1 | Sticky error flag |

## Verification
Directed sequences post, clear and clear-all single sources. They separate per-source clearing from whole-level clearing and show that clear-all beats a simultaneous post. Software-only, external-only and mixed request patterns are committed and read back. This separates the software remapping from the external identity mapping and checks that the summary is an OR of both. Threshold values equal to and one below the pending priority, together with misaligned address values, probe the strict comparison and the alignment gate. A long pseudo-random phase, compared against a behavioural model on every clock, mixes out-of-range indices, stray commits and commit/capture collisions.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int unsigned DEF_LEVELS = 32;
   localparam int unsigned DEF_SRCS   = 8;

   // software request bit idx maps to priority idx - base + 1
   function automatic int sw_prio(input int idx, input int base);
      return idx - base + 1;
   endfunction

endpackage

// File: rtl/intc_level_bank.sv
module intc_level_bank #(
   parameter int LEVELS = 32,
   parameter int SRCS   = 8,
   parameter int LVL_W  = 6,
   parameter int SRC_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             post_v,
   input  logic [LVL_W-1:0] post_lvl,
   input  logic [SRC_W-1:0] post_src,
   input  logic             clr_v,
   input  logic [LVL_W-1:0] clr_lvl,
   input  logic [SRC_W-1:0] clr_src,
   input  logic             clr_all,
   output logic [LEVELS-1:0] status,
   output logic             post_bad,
   output logic             clr_bad
);

   logic post_ok, clr_ok;

   assign post_bad = post_v && ((post_lvl >= LVL_W'(LEVELS)) || (post_src >= SRC_W'(SRCS)));
   assign clr_bad  = clr_v  && ((clr_lvl  >= LVL_W'(LEVELS)) || (clr_src  >= SRC_W'(SRCS)));
   assign post_ok  = post_v && !post_bad;
   assign clr_ok   = clr_v  && !clr_bad;

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      logic [SRCS-1:0] pend;
      logic [SRCS-1:0] set_m, clr_m;

      assign set_m = (post_ok && post_lvl == LVL_W'(l)) ? (SRCS'(1) << post_src) : '0;
      assign clr_m = (clr_ok  && clr_lvl  == LVL_W'(l)) ? (SRCS'(1) << clr_src)  : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       pend <= '0;
         else if (clr_all) pend <= '0;
         else              pend <= (pend & ~clr_m) | set_m;   // set applied last: post wins
      end

      assign status[l] = |pend;
   end

endmodule

// File: rtl/intc_prio_merge.sv
module intc_prio_merge
   import intc_pkg::*;
#(
   parameter int LEVELS  = 32,
   parameter int SW_MIN  = 4,
   parameter int SW_MAX  = 16,
   parameter int EXT_MIN = 16,
   parameter int EXT_MAX = 32,
   parameter int PRIO_W  = 5
) (
   input  logic [LEVELS-1:0] status,
   input  logic [LEVELS-1:0] sw_req,
   output logic [PRIO_W-1:0] prio,
   output logic [LEVELS-1:0] summary
);

   always_comb begin
      prio    = '0;
      summary = '0;
      for (int i = SW_MIN; i < SW_MAX; i++) begin
         if (sw_req[i]) begin
            prio       = PRIO_W'(sw_prio(i, SW_MIN));
            summary[i] = 1'b1;
         end
      end
      for (int i = EXT_MIN; i < EXT_MAX; i++) begin
         if (status[i]) begin
            prio       = PRIO_W'(i);
            summary[i] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/intc_info_regs.sv
module intc_info_regs #(
   parameter int LEVELS = 32,
   parameter int PRIO_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [PRIO_W-1:0] prio,
   input  logic [LEVELS-1:0] summary,
   input  logic              commit,
   output logic [PRIO_W-1:0] hold_prio,
   output logic [LEVELS-1:0] hold_sum,
   output logic [LEVELS-1:0] summary_q,
   output logic [PRIO_W-1:0] intid_q,
   output logic              info_pending,
   output logic              stray_commit
);

   assign stray_commit = commit && !info_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_prio    <= '0;
         hold_sum     <= '0;
         summary_q    <= '0;
         intid_q      <= '0;
         info_pending <= 1'b0;
      end else begin
         if (take) begin
            hold_prio <= prio;
            hold_sum  <= summary;
         end
         if (commit && info_pending) begin
            intid_q   <= hold_prio;
            summary_q <= hold_sum;
         end
         info_pending <= take || (info_pending && !commit);
      end
   end

endmodule

// File: rtl/intc_leveled.sv
module intc_leveled #(
   parameter int LEVELS     = intc_pkg::DEF_LEVELS,
   parameter int SRCS       = intc_pkg::DEF_SRCS,
   parameter int SW_MIN     = 4,
   parameter int SW_MAX     = 16,
   parameter int EXT_MIN    = 16,
   parameter int EXT_MAX    = 32,
   parameter bit ALIGN_GATE = 1'b1,
   localparam int LVL_W     = $clog2(LEVELS) + 1,
   localparam int SRC_W     = $clog2(SRCS) + 1,
   localparam int PRIO_W    = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              post_v,
   input  logic [LVL_W-1:0]  post_lvl,
   input  logic [SRC_W-1:0]  post_src,
   input  logic              clr_v,
   input  logic [LVL_W-1:0]  clr_lvl,
   input  logic [SRC_W-1:0]  clr_src,
   input  logic              clr_all,
   input  logic [LEVELS-1:0] sw_req,
   input  logic [PRIO_W-1:0] threshold,
   input  logic [1:0]        pc_low,
   input  logic              commit,
   output logic              int_avail,
   output logic              take_req,
   output logic [LEVELS-1:0] summary_q,
   output logic [PRIO_W-1:0] intid_q,
   output logic              info_pending,
   output logic              err
);

   if (SW_MIN < 1 || SW_MIN >= SW_MAX || SW_MAX > LEVELS)
      $error("software band out of range");
   if (EXT_MIN < 1 || EXT_MIN >= EXT_MAX || EXT_MAX > LEVELS)
      $error("external band out of range");
   if (SW_MAX - SW_MIN >= LEVELS)
      $error("software priorities do not fit");

   logic [LEVELS-1:0] status;
   logic [LEVELS-1:0] summary;
   logic [LEVELS-1:0] hold_sum;
   logic [PRIO_W-1:0] prio;
   logic [PRIO_W-1:0] hold_prio;
   logic              post_bad, clr_bad, stray_commit;
   logic              aligned;

   if (ALIGN_GATE) begin : g_align
      assign aligned = (pc_low == 2'b00);
   end else begin : g_noalign
      assign aligned = 1'b1;
   end

   intc_level_bank #(.LEVELS(LEVELS), .SRCS(SRCS), .LVL_W(LVL_W), .SRC_W(SRC_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .post_v(post_v), .post_lvl(post_lvl), .post_src(post_src),
      .clr_v(clr_v), .clr_lvl(clr_lvl), .clr_src(clr_src),
      .clr_all(clr_all), .status(status),
      .post_bad(post_bad), .clr_bad(clr_bad)
   );

   intc_prio_merge #(.LEVELS(LEVELS), .SW_MIN(SW_MIN), .SW_MAX(SW_MAX),
                     .EXT_MIN(EXT_MIN), .EXT_MAX(EXT_MAX), .PRIO_W(PRIO_W)) u_merge (
      .status(status), .sw_req(sw_req), .prio(prio), .summary(summary)
   );

   assign int_avail = aligned && (status != '0);
   assign take_req  = aligned && (prio > threshold);

   intc_info_regs #(.LEVELS(LEVELS), .PRIO_W(PRIO_W)) u_info (
      .clk(clk), .rst_n(rst_n), .take(take_req), .prio(prio), .summary(summary),
      .commit(commit), .hold_prio(hold_prio), .hold_sum(hold_sum),
      .summary_q(summary_q), .intid_q(intid_q),
      .info_pending(info_pending), .stray_commit(stray_commit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err <= 1'b0;
      else        err <= err || post_bad || clr_bad || stray_commit;
   end

endmodule

// File: rtl/intc_leveled_chk.sv
module intc_leveled_chk #(
   parameter int LEVELS = 32,
   parameter int SRCS   = 8,
   parameter int LVL_W  = 6,
   parameter int SRC_W  = 4,
   parameter int PRIO_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              post_v,
   input logic [LVL_W-1:0]  post_lvl,
   input logic [SRC_W-1:0]  post_src,
   input logic              clr_v,
   input logic              clr_all,
   input logic              commit,
   input logic [PRIO_W-1:0] threshold,
   input logic [1:0]        pc_low,
   input logic [LEVELS-1:0] status,
   input logic              int_avail,
   input logic              take_req,
   input logic [PRIO_W-1:0] hold_prio,
   input logic [LEVELS-1:0] hold_sum,
   input logic [LEVELS-1:0] summary_q,
   input logic [PRIO_W-1:0] intid_q,
   input logic              info_pending,
   input logic              err
);

   assert_clear_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (status == '0));

   assert_avail_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int_avail |-> (pc_low == 2'b00 && status != '0));

   assert_take_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      take_req |=> (info_pending && hold_prio > $past(threshold)));

   assert_commit_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && info_pending) |=> (intid_q == $past(hold_prio) && summary_q == $past(hold_sum)));

   assert_bad_post_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (post_v && (post_lvl >= LVL_W'(LEVELS) || post_src >= SRC_W'(SRCS)) && !clr_v && !clr_all)
      |=> ($stable(status) && err));

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   assert_stray_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !info_pending) |=> (err && $stable(intid_q) && $stable(summary_q)));

endmodule

bind intc_leveled intc_leveled_chk #(
   .LEVELS(LEVELS), .SRCS(SRCS), .LVL_W(LVL_W), .SRC_W(SRC_W), .PRIO_W(PRIO_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .post_v(post_v), .post_lvl(post_lvl), .post_src(post_src),
   .clr_v(clr_v), .clr_all(clr_all), .commit(commit), .threshold(threshold),
   .pc_low(pc_low), .status(status), .int_avail(int_avail), .take_req(take_req),
   .hold_prio(hold_prio), .hold_sum(hold_sum), .summary_q(summary_q),
   .intid_q(intid_q), .info_pending(info_pending), .err(err)
);

// File: tb/tb_intc_leveled.sv
module tb_intc_leveled;

   localparam int LEVELS = 32;
   localparam int SRCS   = 8;
   localparam int LVL_W  = 6;
   localparam int SRC_W  = 4;
   localparam int PRIO_W = 5;
   localparam int SW_MIN = 4, SW_MAX = 16, EXT_MIN = 16, EXT_MAX = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              post_v = 1'b0, clr_v = 1'b0, clr_all = 1'b0, commit = 1'b0;
   logic [LVL_W-1:0]  post_lvl = '0, clr_lvl = '0;
   logic [SRC_W-1:0]  post_src = '0, clr_src = '0;
   logic [LEVELS-1:0] sw_req = '0;
   logic [PRIO_W-1:0] threshold = '0;
   logic [1:0]        pc_low = 2'b00;
   logic              int_avail, take_req, info_pending, err;
   logic [LEVELS-1:0] summary_q;
   logic [PRIO_W-1:0] intid_q;

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   bit [SRCS-1:0] m_pend [LEVELS];
   bit [31:0]     m_sum_q, m_hold_sum;
   int            m_id_q, m_hold_id;
   bit            m_info, m_err;

   always #10 clk = ~clk;   // 50 MHz

   intc_leveled dut (
      .clk(clk), .rst_n(rst_n), .post_v(post_v), .post_lvl(post_lvl), .post_src(post_src),
      .clr_v(clr_v), .clr_lvl(clr_lvl), .clr_src(clr_src), .clr_all(clr_all),
      .sw_req(sw_req), .threshold(threshold), .pc_low(pc_low), .commit(commit),
      .int_avail(int_avail), .take_req(take_req), .summary_q(summary_q),
      .intid_q(intid_q), .info_pending(info_pending), .err(err)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit lvl_on(input int l);
      return m_pend[l] != '0;
   endfunction

   task automatic model_eval(output int pr, output bit [31:0] sm);
      pr = 0; sm = '0;
      for (int i = 0; i < LEVELS; i++) begin
         if (i >= SW_MIN && i < SW_MAX && sw_req[i]) begin
            if (i - SW_MIN + 1 > pr) pr = i - SW_MIN + 1;
            sm[i] = 1'b1;
         end
      end
      for (int i = 0; i < LEVELS; i++) begin
         if (i >= EXT_MIN && i < EXT_MAX && lvl_on(i)) begin
            if (i > pr) pr = i;
            sm[i] = 1'b1;
         end
      end
   endtask

   // one clock: compare at the falling edge, advance the model at the rising edge
   task automatic cyc();
      int        pr;
      bit [31:0] sm;
      bit        any, algn, tk, pbad, cbad;
      bit [SRCS-1:0] np [LEVELS];
      bit [31:0] n_sum_q, n_hold_sum;
      int        n_id_q, n_hold_id;
      bit        n_info, n_err;
      @(negedge clk);
      model_eval(pr, sm);
      any = 1'b0;
      for (int l = 0; l < LEVELS; l++) if (lvl_on(l)) any = 1'b1;
      algn = (pc_low == 2'b00);
      tk   = algn && (pr > int'(threshold));
      chk("R4 int_avail", int_avail, algn && any);
      chk("R7 take_req", take_req, tk);
      chk("R7 info_pending", info_pending, m_info);
      chk("R8 intid_q", intid_q, m_id_q);
      chk("R8 summary_q", summary_q, m_sum_q);
      chk("R9 err", err, m_err);
      pbad = post_v && (int'(post_lvl) >= LEVELS || int'(post_src) >= SRCS);
      cbad = clr_v  && (int'(clr_lvl)  >= LEVELS || int'(clr_src)  >= SRCS);
      np = m_pend;
      if (clr_all) begin
         for (int l = 0; l < LEVELS; l++) np[l] = '0;
      end else begin
         if (clr_v && !cbad) np[clr_lvl][clr_src] = 1'b0;
         if (post_v && !pbad) np[post_lvl][post_src] = 1'b1;
      end
      n_hold_id = tk ? pr : m_hold_id;
      n_hold_sum = tk ? sm : m_hold_sum;
      n_id_q  = (commit && m_info) ? m_hold_id  : m_id_q;
      n_sum_q = (commit && m_info) ? m_hold_sum : m_sum_q;
      n_info  = tk || (m_info && !commit);
      n_err   = m_err || pbad || cbad || (commit && !m_info);
      @(posedge clk);
      #1;
      m_pend = np; m_hold_id = n_hold_id; m_hold_sum = n_hold_sum;
      m_id_q = n_id_q; m_sum_q = n_sum_q; m_info = n_info; m_err = n_err;
   endtask

   task automatic idle();
      post_v = 1'b0; clr_v = 1'b0; clr_all = 1'b0; commit = 1'b0;
   endtask

   task automatic do_reset();
      idle();
      rst_n = 1'b0;
      for (int l = 0; l < LEVELS; l++) m_pend[l] = '0;
      m_sum_q = '0; m_hold_sum = '0; m_id_q = 0; m_hold_id = 0; m_info = 1'b0; m_err = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic do_post(input int l, input int s);
      post_v = 1'b1; post_lvl = LVL_W'(l); post_src = SRC_W'(s);
      cyc(); idle(); #1;
   endtask

   task automatic do_clear(input int l, input int s);
      clr_v = 1'b1; clr_lvl = LVL_W'(l); clr_src = SRC_W'(s);
      cyc(); idle(); #1;
   endtask

   // capture on one edge, commit on the next
   task automatic capture_commit();
      cyc();
      commit = 1'b1; cyc(); commit = 1'b0; #1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      #1;
      // R11: reset state
      chk("R11 int_avail", int_avail, 0);
      chk("R11 summary_q", summary_q, 0);
      chk("R11 intid_q", intid_q, 0);
      chk("R11 info_pending", info_pending, 0);
      chk("R11 err", err, 0);

      // R10: stray commit
      commit = 1'b1; cyc(); commit = 1'b0; #1;
      chk("R10 err after stray commit", err, 1);
      chk("R10 intid_q unchanged", intid_q, 0);
      do_reset();
      #1;
      chk("R11 err cleared by reset", err, 0);

      // R1, R6, R8: external post, capture, commit
      threshold = '0;
      do_post(20, 3);
      chk("R1 level 20 active", int_avail, 1);
      chk("R7 take_req high", take_req, 1);
      cyc(); #1;
      chk("R7 info_pending after capture", info_pending, 1);
      commit = 1'b1; cyc(); commit = 1'b0; #1;
      chk("R8 intid_q", intid_q, 20);
      chk("R8 summary_q", summary_q, 32'h0010_0000);

      // R7: strict greater-than
      threshold = 5'd20; #1;
      chk("R7 equal threshold blocks", take_req, 0);
      threshold = 5'd19; #1;
      chk("R7 lower threshold passes", take_req, 1);
      threshold = 5'd31;
      cyc();
      commit = 1'b1; cyc(); commit = 1'b0; #1;

      // R2: per-source clearing
      do_post(20, 5);
      do_clear(20, 3);
      chk("R2 level kept by other source", int_avail, 1);
      do_clear(20, 5);
      chk("R2 level dropped", int_avail, 0);

      // R5: software remap
      threshold = '0;
      sw_req = 32'h0000_0004; #1;
      chk("R5 band-excluded bit ignored", take_req, 0);
      sw_req = 32'h0000_0040;
      capture_commit();
      chk("R5 software priority", intid_q, 3);
      chk("R5 software summary", summary_q, 32'h0000_0040);
      chk("R4 software alone no avail", int_avail, 0);

      // R6: external beats software, summary ORs
      do_post(17, 0);
      capture_commit();
      chk("R6 external wins", intid_q, 17);
      chk("R6 merged summary", summary_q, 32'h0002_0040);

      // R4: misaligned address
      pc_low = 2'b10; #1;
      chk("R4 misaligned avail", int_avail, 0);
      chk("R7 misaligned take", take_req, 0);
      pc_low = 2'b00;
      sw_req = '0;
      do_clear(17, 0);

      // R12: post and clear of the same bit
      post_v = 1'b1; post_lvl = 6'd22; post_src = 4'd1;
      clr_v = 1'b1; clr_lvl = 6'd22; clr_src = 4'd1;
      cyc(); idle(); #1;
      chk("R12 post wins", int_avail, 1);

      // R9: out-of-range indices
      do_post(40, 0);
      chk("R9 err after bad level", err, 1);
      do_post(23, 9);
      capture_commit();
      chk("R9 bad source ignored", intid_q, 22);

      // R3: clear-all overrides a same-cycle post
      clr_all = 1'b1; post_v = 1'b1; post_lvl = 6'd25; post_src = 4'd2;
      cyc(); idle(); #1;
      chk("R3 all levels empty", int_avail, 0);

      // mixed pseudo-random phase, model compared every clock
      do_reset();
      for (int n = 0; n < 3000; n++) begin
         post_v   = ($urandom % 3) == 0;
         post_lvl = LVL_W'($urandom % 40);
         post_src = SRC_W'($urandom % 10);
         clr_v    = ($urandom % 4) == 0;
         clr_lvl  = (($urandom % 2) == 0) ? post_lvl : LVL_W'($urandom % 40);
         clr_src  = (($urandom % 2) == 0) ? post_src : SRC_W'($urandom % 10);
         clr_all  = ($urandom % 60) == 0;
         commit   = ($urandom % 4) == 0;
         threshold = PRIO_W'($urandom % 32);
         pc_low   = (($urandom % 6) == 0) ? 2'($urandom % 4) : 2'b00;
         if (($urandom % 8) == 0) sw_req = $urandom;
         if (n % 500 == 499) do_reset();
         else cyc();
      end
      idle();
      cyc();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule